// File: doc/BRIEF.md
# SerDes Endpoint Mode and Direction Controller

This block holds the control state of one end of a bidirectional serial link. Two asynchronous mode pins pick either a power-down state or one of three reference-frequency ranges. A direction input then selects whether the endpoint serializes (direction high) or deserializes (direction low). The block turns that choice into enable outputs for the serializer, the deserializer, the parallel output drivers and the reference-clock PLL. It also drives an inverted copy of the direction input, which goes to the link partner so that the two ends turn around together.

The serializer starts out clocked by a bit clock supplied from outside. The first reference-clock transition seen outside power-down latches reference-clock operation. That choice can only be undone by a power-down in which the reference clock is sampled low. A loss detector watches for reference-clock edges. When the reference stops at either level, it idles the PLL and the serial path without resetting the sticky clock-source choice. The next edge restores both.

After the endpoint leaves power-down, or after the reference clock comes back, a data-valid flag stays low until a programmable lock-wait count has passed. This is a control block with plain level pins and carries no data stream.

Top module: `serdes_mode_ctrl`

## Requirements
- R1: With both synchronized mode pins at 0 (power-down), `pwr_down` is 1 and `ser_en`, `des_en`, `par_oe`, `pll_en`, `use_ref` (if the reference is low) and `data_valid` are 0, and `freq_sel` is 00. After reset the block is in power-down with `ref_lost` = 1 and `use_ref` = 0.
- R2: With mode pins 01, 10 or 11, `freq_sel` equals the pin code. Direction 1 selects the serializer (`ser_en`) and direction 0 selects the deserializer (`des_en`). The two are never high together.
- R3: `dir_out` is the combinational inverse of `dir_in` in every mode, including power-down.
- R4: `par_oe` is 1 only in deserializer mode, and 0 in serializer mode and in power-down.
- R5: `use_ref` is 0 after power-up. It goes to 1 on the first reference-clock edge seen outside power-down. Once set, it stays 1 when the reference clock stops.
- R6: `use_ref` is cleared only in power-down while the synchronized reference clock is low. A power-down with the reference held high keeps it at 1.
- R7: When no reference edge has been seen for LOSS_CYCLES (default 64) clock cycles, `ref_lost` goes to 1. While `use_ref` is 1, this drops `pll_en`, `ser_en`, `des_en` and `data_valid`.
- R8: A reference edge outside power-down clears `ref_lost` on the next cycle and restores `pll_en` when `use_ref` is 1.
- R9: `data_valid` rises only after `lock_cycles` consecutive cycles in which the link is running. The link is running when it is out of power-down and not (using the reference and lost). The count restarts whenever the link stops running.
- R10: Mode and direction pins pass through a two-flop synchronizer. A change is not visible on the outputs one clock after it is applied, and is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 2 | Asynchronous mode pins: 00 power-down, else frequency range |
| dir_in | input | 1 | Direction: 1 serializer, 0 deserializer |
| ref_clk | input | 1 | Asynchronous reference clock being monitored |
| lock_cycles | input | LOCK_W | Lock-wait count before data is valid |
| dir_out | output | 1 | Inverse of dir_in, for the link partner |
| pwr_down | output | 1 | Power-down state active |
| freq_sel | output | 2 | Selected reference-frequency range (00 in power-down) |
| ser_en | output | 1 | Serializer path enable |
| des_en | output | 1 | Deserializer path enable |
| par_oe | output | 1 | Parallel bidirectional pin drive enable |
| pll_en | output | 1 | Reference-clock PLL enable |
| use_ref | output | 1 | Sticky: serializer clocked from the reference, not the external bit clock |
| ref_lost | output | 1 | No reference edge within LOSS_CYCLES |
| data_valid | output | 1 | Lock wait elapsed, link running |

## Verification
The bench sweeps every mode-pin code against both directions and checks the decode. A swapped decode would show a wrong range code or both paths enabled. It measures the pin-synchronizer latency edge by edge, which catches a missing or extra stage. It also brackets the loss window at 60 and 70 cycles and the lock wait at one count below and above its limit, which catches a detector with the wrong threshold or a timer that does not restart. Power-down is entered with the reference stopped high and then stopped low. A clock-source flag that clears on any power-down, or never clears, fails one of these two checks.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    OP_OFF = 2'd0,
    OP_SER = 2'd1,
    OP_DES = 2'd2
  } op_mode_e;

  localparam logic [1:0] PINS_OFF = 2'b00;
endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/smc_mode_decode.sv
module smc_mode_decode
  import smc_pkg::*;
(
  input  logic [1:0] mode_s,
  input  logic       dir_s,
  output op_mode_e   op,
  output logic [1:0] freq_sel
);
  always_comb begin
    freq_sel = mode_s;
    if (mode_s == PINS_OFF) op = OP_OFF;
    else if (dir_s)         op = OP_SER;
    else                    op = OP_DES;
  end
endmodule

// File: rtl/smc_refclk_mon.sv
module smc_refclk_mon #(
  parameter int LOSS_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  input  logic pwr_down,
  output logic use_ref,
  output logic ref_lost
);
  localparam int              LW       = $clog2(LOSS_CYCLES + 1);
  localparam logic [LW-1:0]   LOSS_MAX = LW'(LOSS_CYCLES);

  logic          ref_s, ref_d, ref_edge;
  logic [LW-1:0] idle_cnt;

  smc_sync #(.W(1), .STAGES(2)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .d(ref_async), .q(ref_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_d <= 1'b0;
    else        ref_d <= ref_s;
  end

  assign ref_edge = ref_s ^ ref_d;

  // cycles since the last reference edge, saturating at the loss limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_cnt <= LOSS_MAX;
    else if (pwr_down)            idle_cnt <= LOSS_MAX;
    else if (ref_edge)            idle_cnt <= '0;
    else if (idle_cnt != LOSS_MAX) idle_cnt <= idle_cnt + 1'b1;
  end

  // sticky clock-source choice; only a low reference in power-down clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        use_ref <= 1'b0;
    else if (pwr_down) begin
      if (!ref_s)      use_ref <= 1'b0;
    end
    else if (ref_edge) use_ref <= 1'b1;
  end

  assign ref_lost = (idle_cnt == LOSS_MAX);

  a_r5_sticky_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (use_ref && !pwr_down) |=> use_ref);
  a_r6_clear_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(use_ref) |-> $past(pwr_down));
  a_r8_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !pwr_down) |=> !ref_lost);
endmodule

// File: rtl/smc_lock_timer.sv
module smc_lock_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt < limit) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt >= limit);

  a_r9_rise_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && limit != '0) |-> $past(run));
  a_r9_stop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && limit != '0 && $stable(limit)) |=> !done);
endmodule

// File: rtl/serdes_mode_ctrl.sv
module serdes_mode_ctrl
  import smc_pkg::*;
#(
  parameter int LOSS_CYCLES = 64,
  parameter int LOCK_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_pins,
  input  logic              dir_in,
  input  logic              ref_clk,
  input  logic [LOCK_W-1:0] lock_cycles,
  output logic              dir_out,
  output logic              pwr_down,
  output logic [1:0]        freq_sel,
  output logic              ser_en,
  output logic              des_en,
  output logic              par_oe,
  output logic              pll_en,
  output logic              use_ref,
  output logic              ref_lost,
  output logic              data_valid
);
  logic [2:0] pin_s;
  op_mode_e   op;
  logic       link_run;

  // turnaround path stays combinational so the partner follows at once
  assign dir_out = ~dir_in;

  smc_sync #(.W(3), .STAGES(2)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d({dir_in, mode_pins}), .q(pin_s)
  );

  smc_mode_decode u_decode (
    .mode_s(pin_s[1:0]), .dir_s(pin_s[2]), .op(op), .freq_sel(freq_sel)
  );

  assign pwr_down = (op == OP_OFF);

  smc_refclk_mon #(.LOSS_CYCLES(LOSS_CYCLES)) u_refmon (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_clk), .pwr_down(pwr_down),
    .use_ref(use_ref), .ref_lost(ref_lost)
  );

  assign link_run = !pwr_down && !(use_ref && ref_lost);
  assign ser_en   = (op == OP_SER) && link_run;
  assign des_en   = (op == OP_DES) && link_run;
  assign par_oe   = (op == OP_DES);
  assign pll_en   = !pwr_down && use_ref && !ref_lost;

  smc_lock_timer #(.CW(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .run(link_run), .limit(lock_cycles),
    .done(data_valid)
  );

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !(ser_en || des_en || par_oe || pll_en || data_valid));
  a_r2_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ser_en, des_en}));
  a_r4_no_drive_ser: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !par_oe);
  a_r7_lost_idles_pll: assert property (@(posedge clk) disable iff (!rst_n)
    ref_lost |-> !pll_en);
endmodule

// File: tb/serdes_mode_ctrl_bench.sv
module serdes_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_pins;
  logic dir_in;
  logic ref_run, ref_tog, ref_level;
  logic [7:0] lock_cycles;
  logic dir_out, pwr_down, ser_en, des_en, par_oe, pll_en, use_ref, ref_lost, data_valid;
  logic [1:0] freq_sel;
  logic ref_clk;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign ref_clk = ref_run ? ref_tog : ref_level;

  initial ref_tog = 1'b0;
  always begin
    repeat (4) @(posedge clk);
    #2;
    if (ref_run) ref_tog = ~ref_tog;
  end

  serdes_mode_ctrl u_serdes_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .dir_in(dir_in),
    .ref_clk(ref_clk), .lock_cycles(lock_cycles), .dir_out(dir_out),
    .pwr_down(pwr_down), .freq_sel(freq_sel), .ser_en(ser_en), .des_en(des_en),
    .par_oe(par_oe), .pll_en(pll_en), .use_ref(use_ref), .ref_lost(ref_lost),
    .data_valid(data_valid)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; mode_pins = 2'b00; dir_in = 1'b1;
    ref_run = 1'b0; ref_level = 1'b0; lock_cycles = 8'd12;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 pwr_down", pwr_down, 1);
    check("R1 outputs", {ser_en, des_en, par_oe, pll_en, data_valid}, 0);
    check("R1 ref_lost", ref_lost, 1);
    check("R5 use_ref at start", use_ref, 0);
    check("R3 dir_out", dir_out, 0);

    // R10 synchronizer latency, R5 external bit clock, R9 lock wait
    mode_pins = 2'b01; dir_in = 1'b1;
    step(1);
    check("R10 one edge", pwr_down, 1);
    step(1);
    check("R10 two edges", pwr_down, 0);
    check("R2 freq_sel 01", freq_sel, 1);
    check("R5 ext clock ser_en", {ser_en, use_ref, pll_en}, 3'b100);
    step(11);
    check("R9 before lock", data_valid, 0);
    step(2);
    check("R9 after lock", data_valid, 1);

    // R2/R3/R4 sweep of every code and direction
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        mode_pins = 2'(m); dir_in = 1'(d);
        #1;
        check("R3 comb invert", dir_out, 32'(1 - d));
        step(3);
        if (m == 0) begin
          check("R1 sweep pd", {pwr_down, ser_en, des_en, par_oe, pll_en}, 5'b10000);
          check("R2 freq_sel pd", freq_sel, 0);
        end else begin
          check("R2 freq_sel", freq_sel, 32'(m));
          check("R2 ser_en", ser_en, 32'(d));
          check("R2 des_en", des_en, 32'(1 - d));
          check("R4 par_oe", par_oe, 32'(1 - d));
        end
      end
    end

    // R5 switch to reference clock, R8 pll up
    mode_pins = 2'b11; dir_in = 1'b1;
    step(3);
    ref_run = 1'b1;
    step(20);
    check("R5 use_ref set", use_ref, 1);
    check("R8 pll_en", {pll_en, ref_lost}, 2'b10);

    // R7 loss window
    ref_level = ref_tog; ref_run = 1'b0;
    step(60);
    check("R7 not lost at 60", ref_lost, 0);
    step(10);
    check("R7 lost at 70", ref_lost, 1);
    check("R7 idled", {pll_en, ser_en, data_valid}, 0);
    check("R5 sticky after stop", use_ref, 1);

    // R8/R9 regain
    ref_run = 1'b1;
    step(10);
    check("R8 lost cleared", {ref_lost, pll_en, ser_en}, 3'b011);
    check("R9 relock wait", data_valid, 0);
    step(20);
    check("R9 relocked", data_valid, 1);

    // R6 power-down with reference held high keeps the choice
    while (ref_tog !== 1'b1) step(1);
    ref_level = 1'b1; ref_run = 1'b0;
    mode_pins = 2'b00;
    step(6);
    check("R6 pd high keeps", use_ref, 1);
    mode_pins = 2'b11;
    step(6);
    check("R6 kept after pd", {use_ref, ref_lost, pll_en, ser_en}, 4'b1100);

    // R6 power-down with reference low clears it
    mode_pins = 2'b00; ref_level = 1'b0;
    step(6);
    check("R6 pd low clears", use_ref, 0);
    mode_pins = 2'b11;
    step(6);
    check("R6 ext mode back", {use_ref, ser_en, pll_en}, 3'b010);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule